// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counters

This block keeps two frame statistics for an Ethernet MAC. The MAC core reports each finished transmit frame with a one-cycle strobe. The strobe carries the number of collisions the frame met and a flag saying whether the frame was given up. The core reports each finished receive frame with a one-cycle strobe too. That strobe carries the byte length and flags for address match, storage to memory, FCS error, alignment error and symbol error. The block checks each report against the rules for its counter and, when the frame qualifies, adds one to a saturating counter.

Software reads and writes both counters through a plain 32-bit register port, either to preset them or to clear them. A write and a read address share one address bus, and read data follows the address combinationally. The status strobes have no ready signal. The block takes a report on every cycle, so it never applies back-pressure and the MAC core never has to hold a report.

Top module: `enet_stat_counters`

## Requirements
- R1: A transmit strobe with the abandon flag low and a collision count from 2 to 15 inclusive adds one to the multiple-collision counter.
- R2: A transmit strobe with a collision count of 0, 1 or above 15, or with the abandon flag high, leaves the multiple-collision counter unchanged.
- R3: A receive strobe adds to the good-frame counter only when both the address-match flag and the stored-to-memory flag are high.
- R4: A good frame is 64 to 1518 bytes long. When `cfg_long_frames` is 1, the upper bound is 1522 bytes. A frame outside the bound in force is not counted.
- R5: A receive strobe with the FCS, alignment or symbol error flag high is never counted, even when its length is valid.
- R6: Offset 0x48 holds the multiple-collision counter in bits 15:0. Offset 0x4C holds the good-frame counter in bits 23:0. Any other offset reads as 0.
- R7: Reserved bits (31:16 at 0x48, 31:24 at 0x4C) always read as 0, and writing them has no effect.
- R8: A write with `reg_wr` high loads the counter field at the addressed offset from `reg_wdata`. The new value is readable in the next cycle.
- R9: A counter at its maximum (0xFFFF or 0xFFFFFF) stays there when another qualifying frame arrives.
- R10: When a software write and a qualifying frame reach the same counter in the same cycle, the counter takes the written value.
- R11: A synchronous active-high `rst` clears both counters to 0.
- R12: A qualifying strobe sampled at a clock edge is visible on `reg_rdata` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_done_vld | input | 1 | Transmit completion strobe |
| tx_coll_cnt | input | 5 | Collisions met by the frame |
| tx_abandon | input | 1 | Frame was given up after too many collisions |
| rx_done_vld | input | 1 | Receive completion strobe |
| rx_len | input | 14 | Frame length in bytes |
| rx_addr_hit | input | 1 | Destination address was recognized |
| rx_stored | input | 1 | Frame was fully written to memory |
| rx_fcs_err | input | 1 | FCS check failed |
| rx_align_err | input | 1 | Alignment error |
| rx_sym_err | input | 1 | Receive symbol error |
| cfg_long_frames | input | 1 | Raises the good-frame length limit to 1522 |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
A software write and a hardware increment can reach the same counter in the same clock cycle. The bench sets this up by raising `reg_wr` at a counter's offset in the same cycle as a qualifying transmit or receive strobe. It then reads the counter back and expects exactly the written value, with no added one. The bench also presets each counter to just below its maximum and sends qualifying frames, to check that the counter stops at its ceiling.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned COLL_CW    = 5;
  localparam int unsigned LEN_W      = 14;
  localparam int unsigned MCOL_W     = 16;
  localparam int unsigned GOOD_W     = 24;
  localparam logic [ADDR_W-1:0] MCOL_OFS = 8'h48;
  localparam logic [ADDR_W-1:0] GOOD_OFS = 8'h4C;
endpackage

// File: rtl/esc_tx_qual.sv
module esc_tx_qual #(
  parameter int unsigned CW      = 5,
  parameter int unsigned COLL_LO = 2,
  parameter int unsigned COLL_HI = 15
) (
  input  logic          done_vld,
  input  logic [CW-1:0] coll_cnt,
  input  logic          abandon,
  output logic          bump
);
  localparam logic [CW-1:0] LO = CW'(COLL_LO);
  localparam logic [CW-1:0] HI = CW'(COLL_HI);

  // R1/R2: only successful sends inside the collision window qualify
  always_comb begin
    bump = done_vld && !abandon && (coll_cnt >= LO) && (coll_cnt <= HI);
  end
endmodule

// File: rtl/esc_rx_qual.sv
module esc_rx_qual #(
  parameter int unsigned LW          = 14,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned MAX_LEN     = 1518,
  parameter int unsigned MAX_LEN_EXT = 1522
) (
  input  logic          done_vld,
  input  logic [LW-1:0] len,
  input  logic          addr_hit,
  input  logic          stored,
  input  logic          fcs_err,
  input  logic          align_err,
  input  logic          sym_err,
  input  logic          long_ok,
  output logic          bump
);
  localparam logic [LW-1:0] LMIN = LW'(MIN_LEN);
  localparam logic [LW-1:0] LMAX = LW'(MAX_LEN);
  localparam logic [LW-1:0] LEXT = LW'(MAX_LEN_EXT);

  logic [LW-1:0] upper;
  logic          len_ok, accepted, clean;

  always_comb begin
    upper    = long_ok ? LEXT : LMAX;                 // R4
    len_ok   = (len >= LMIN) && (len <= upper);
    accepted = addr_hit && stored;                    // R3
    clean    = !(fcs_err || align_err || sym_err);    // R5
    bump     = done_vld && accepted && clean && len_ok;
  end
endmodule

// File: rtl/esc_sat_counter.sv
module esc_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                   q <= '0;            // R11
    else if (wr)               q <= wdata;         // R8, R10
    else if (inc && q != TOP)  q <= q + W'(1);     // R9
  end

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> q == '0);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    wr |=> q == $past(wdata));

  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (inc && !wr && q != TOP) |=> q == $past(q) + W'(1));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (inc && !wr && q == TOP) |=> q == TOP);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!inc && !wr) |=> $stable(q));
endmodule

// File: rtl/enet_stat_counters.sv
module enet_stat_counters
  import esc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_done_vld,
  input  logic [COLL_CW-1:0]  tx_coll_cnt,
  input  logic                tx_abandon,
  input  logic                rx_done_vld,
  input  logic [LEN_W-1:0]    rx_len,
  input  logic                rx_addr_hit,
  input  logic                rx_stored,
  input  logic                rx_fcs_err,
  input  logic                rx_align_err,
  input  logic                rx_sym_err,
  input  logic                cfg_long_frames,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata
);
  logic              mcol_inc, good_inc, mcol_wr, good_wr;
  logic [MCOL_W-1:0] mcol_q;
  logic [GOOD_W-1:0] good_q;

  esc_tx_qual #(.CW(COLL_CW)) u_txq (
    .done_vld (tx_done_vld),
    .coll_cnt (tx_coll_cnt),
    .abandon  (tx_abandon),
    .bump     (mcol_inc)
  );

  esc_rx_qual #(.LW(LEN_W)) u_rxq (
    .done_vld  (rx_done_vld),
    .len       (rx_len),
    .addr_hit  (rx_addr_hit),
    .stored    (rx_stored),
    .fcs_err   (rx_fcs_err),
    .align_err (rx_align_err),
    .sym_err   (rx_sym_err),
    .long_ok   (cfg_long_frames),
    .bump      (good_inc)
  );

  always_comb begin
    mcol_wr = reg_wr && (reg_addr == MCOL_OFS);
    good_wr = reg_wr && (reg_addr == GOOD_OFS);
  end

  // R7: only the field bits reach the counters
  esc_sat_counter #(.W(MCOL_W)) u_mcol (
    .clk (clk), .rst (rst), .inc (mcol_inc), .wr (mcol_wr),
    .wdata (reg_wdata[MCOL_W-1:0]), .q (mcol_q)
  );

  esc_sat_counter #(.W(GOOD_W)) u_good (
    .clk (clk), .rst (rst), .inc (good_inc), .wr (good_wr),
    .wdata (reg_wdata[GOOD_W-1:0]), .q (good_q)
  );

  // R6/R12: combinational read, zero-extended fields
  always_comb begin
    unique case (reg_addr)
      MCOL_OFS: reg_rdata = {{(REG_W-MCOL_W){1'b0}}, mcol_q};
      GOOD_OFS: reg_rdata = {{(REG_W-GOOD_W){1'b0}}, good_q};
      default:  reg_rdata = '0;
    endcase
  end

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (rx_done_vld && (rx_fcs_err || rx_align_err || rx_sym_err) && !good_wr)
      |=> $stable(good_q));

  assert_abandon_ignored_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (tx_done_vld && tx_abandon && !mcol_wr) |=> $stable(mcol_q));

  assert_unmatched_ignored_R3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (rx_done_vld && !(rx_addr_hit && rx_stored) && !good_wr) |=> $stable(good_q));
endmodule

// File: tb/test_enet_stat_counters.sv
`timescale 1ns/1ps
module test_enet_stat_counters;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_done_vld = 0, tx_abandon = 0;
  logic [4:0]  tx_coll_cnt = 0;
  logic        rx_done_vld = 0, rx_addr_hit = 0, rx_stored = 0;
  logic        rx_fcs_err = 0, rx_align_err = 0, rx_sym_err = 0;
  logic [13:0] rx_len = 0;
  logic        cfg_long_frames = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  int exp_mcol = 0, exp_good = 0;
  bit done = 0;

  always #10 clk = ~clk;

  enet_stat_counters i_enet_stat_counters (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic tx(input int c, input bit ab);
    @(negedge clk);
    tx_done_vld = 1; tx_coll_cnt = 5'(c); tx_abandon = ab;
    @(negedge clk);
    tx_done_vld = 0; tx_abandon = 0;
  endtask

  task automatic rx(input int len, input bit hit, input bit st, input bit f, input bit al, input bit sy);
    @(negedge clk);
    rx_done_vld = 1; rx_len = 14'(len); rx_addr_hit = hit; rx_stored = st;
    rx_fcs_err = f; rx_align_err = al; rx_sym_err = sy;
    @(negedge clk);
    rx_done_vld = 0;
  endtask

  task automatic t_reset;
    rd(8'h48, "R11 mcol after reset", 0);
    rd(8'h4C, "R11 good after reset", 0);
  endtask

  task automatic t_tx_window;
    for (int c = 0; c <= 17; c++) begin
      tx(c, 0);
      if (c >= 2 && c <= 15) exp_mcol++;
    end
    rd(8'h48, "R1 R2 collision window", 32'(exp_mcol));
    tx(5, 1);
    rd(8'h48, "R2 abandoned frame", 32'(exp_mcol));
  endtask

  task automatic t_timing;
    @(negedge clk);
    reg_addr = 8'h48; tx_done_vld = 1; tx_coll_cnt = 3;
    @(negedge clk);
    tx_done_vld = 0; exp_mcol++;
    #1 check("R12 visible after edge", reg_rdata, 32'(exp_mcol));
  endtask

  task automatic t_rx_rules;
    rx(64, 1, 1, 0, 0, 0);   exp_good++;
    rx(1518, 1, 1, 0, 0, 0); exp_good++;
    rd(8'h4C, "R4 length bounds", 32'(exp_good));
    rx(63, 1, 1, 0, 0, 0);
    rx(1519, 1, 1, 0, 0, 0);
    rx(1522, 1, 1, 0, 0, 0);
    rd(8'h4C, "R4 out of range short limit", 32'(exp_good));
    cfg_long_frames = 1;
    rx(1522, 1, 1, 0, 0, 0); exp_good++;
    rx(1523, 1, 1, 0, 0, 0);
    rd(8'h4C, "R4 long limit", 32'(exp_good));
    cfg_long_frames = 0;
    rx(500, 0, 1, 0, 0, 0);
    rx(500, 1, 0, 0, 0, 0);
    rd(8'h4C, "R3 address and storage", 32'(exp_good));
    rx(500, 1, 1, 1, 0, 0);
    rx(500, 1, 1, 0, 1, 0);
    rx(500, 1, 1, 0, 0, 1);
    rd(8'h4C, "R5 error flags", 32'(exp_good));
  endtask

  task automatic t_regmap;
    wr(8'h48, 32'hABCD_1234); exp_mcol = 32'h1234;
    rd(8'h48, "R7 R8 mcol preset reserved", 32'(exp_mcol));
    wr(8'h4C, 32'hFF12_3456); exp_good = 32'h12_3456;
    rd(8'h4C, "R7 R8 good preset reserved", 32'(exp_good));
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, "R6 unmapped offset", 0);
    rd(8'h48, "R6 mcol untouched", 32'(exp_mcol));
    rd(8'h4C, "R6 good untouched", 32'(exp_good));
  endtask

  task automatic t_saturate;
    wr(8'h48, 32'hFFFE);
    tx(4, 0); tx(4, 0);
    rd(8'h48, "R9 mcol saturates", 32'hFFFF);
    wr(8'h4C, 32'hFF_FFFE);
    rx(100, 1, 1, 0, 0, 0); rx(100, 1, 1, 0, 0, 0);
    rd(8'h4C, "R9 good saturates", 32'hFF_FFFF);
  endtask

  task automatic t_collide;
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h48; reg_wdata = 32'h0077;
    tx_done_vld = 1; tx_coll_cnt = 2;
    @(negedge clk);
    reg_wr = 0; tx_done_vld = 0;
    rd(8'h48, "R10 write beats tx increment", 32'h77);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h4C; reg_wdata = 32'h0000_0042;
    rx_done_vld = 1; rx_len = 200; rx_addr_hit = 1; rx_stored = 1;
    rx_fcs_err = 0; rx_align_err = 0; rx_sym_err = 0;
    @(negedge clk);
    reg_wr = 0; rx_done_vld = 0;
    rd(8'h4C, "R10 write beats rx increment", 32'h42);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(8'h48, "R11 mcol cleared", 0);
    rd(8'h4C, "R11 good cleared", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_tx_window();
    t_timing();
    t_rx_rules();
    t_regmap();
    t_saturate();
    t_collide();
    t_rereset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule